// File: doc/BRIEF.md
# Time-Base Tap Interval Timer

This block keeps a free-running 64-bit time base and derives two periodic events from it: a fixed-interval event and a watchdog event. Each event watches a single time-base bit, chosen by a period code in a control register. An event fires only when that bit goes from 0 to 1. Each event sets a flag in a status register. Software clears status flags by writing ones to them, and level interrupt outputs follow each status flag gated by its enable bit.

The period code is decoded in one of two ways, chosen by a parameter. In table mode, a 2-bit code picks one of four bit positions given as a parameter. In extended mode, the 2-bit code and a 4-bit extension together form a 6-bit value, and the tapped bit is 63 minus that value.

The watchdog moves through a three-stage escalation. The first event arms it, the second raises its interrupt status, and the third, if permitted, records a reset code and pulses a reset request. A resume pulse clears the watchdog's status fields together.

Top module: `tbtap_timer`

## Requirements
- R1: The time base `tb_q` is 0 after reset and advances by exactly one on each clock where `tick_en` is 1; otherwise it holds.
- R2: In table mode (`EXT_MODE`=0), fixed-interval code `ctl[25:24]` selects bit `FIT_TAPS[6*code +: 6]` and watchdog code `ctl[31:30]` selects bit `WDG_TAPS[6*code +: 6]`. With the defaults, fixed-interval codes 0..3 select bits 3, 5, 7 and 9, and watchdog codes 0..3 select bits 4, 6, 8 and 10.
- R3: In extended mode, the fixed-interval extension is `ctl[16:13]` and the watchdog extension is `ctl[20:17]`. The tapped bit is 63 − {extension, code}.
- R4: An event occurs only on the tick where the tapped time-base bit goes from 0 to 1. The fixed-interval event sets status bit 26 (`sts_q[26]`) in that same clock. A 1-to-0 transition causes no event.
- R5: A write to the status register clears each status bit written as 1 and leaves bits written as 0 unchanged. An event arriving in the same cycle as a write wins.
- R6: `fit_irq` = `sts_q[26]` AND `ctl_q[23]`, and `wdog_irq` = `sts_q[30]` AND `ctl_q[27]`. Changing the enable alone does not alter the status bit.
- R7: A watchdog event sets `sts_q[31]` (arm) when it is clear. Otherwise it sets `sts_q[30]` (watchdog status) when that is clear.
- R8: A watchdog event with `sts_q[31]` and `sts_q[30]` both set copies `ctl[29:28]` into `sts_q[29:28]` and pulses `wdog_rst_req` for one cycle, unless `ctl[29:28]` is 0, in which case nothing changes.
- R9: A `resume` pulse clears `sts_q[31:28]` and suppresses any watchdog action in that cycle.
- R10: Reset clears the control register, every status bit, the time base and all outputs. `sts_q[27]` and `sts_q[25:0]` always read 0.
- R11: A control write stores all 32 bits of `wdata`, and they read back on `ctl_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Time-base advance enable |
| wr_ctl | input | 1 | Write `wdata` into the control register |
| wr_sts | input | 1 | Write-one-to-clear the status register with `wdata` |
| wdata | input | 32 | Register write data |
| resume | input | 1 | Clears the watchdog status fields |
| ctl_q | output | 32 | Control register value |
| sts_q | output | 32 | Status register value |
| tb_q | output | 64 | Time base value |
| fit_irq | output | 1 | Fixed-interval interrupt level |
| wdog_irq | output | 1 | Watchdog interrupt level |
| wdog_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The assertions assume that `wr_ctl`, `wr_sts`, `resume` and `tick_en` are sampled synchronously. They also assume that a control write changes the tap only between ticks, so an edge is judged against the old and new value of a single bit. The bench drives all inputs at the falling edge and raises each write or resume strobe for exactly one clock with `tick_en` low. It advances the time base only through counted tick bursts from a fresh reset, so the expected tap crossings are known in advance.

// File: rtl/tbtap_timer.sv
module tbtap_timer #(
  parameter bit          EXT_MODE = 1'b0,
  parameter logic [23:0] FIT_TAPS = {6'd9, 6'd7, 6'd5, 6'd3},
  parameter logic [23:0] WDG_TAPS = {6'd10, 6'd8, 6'd6, 6'd4}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        wr_ctl,
  input  logic        wr_sts,
  input  logic [31:0] wdata,
  input  logic        resume,
  output logic [31:0] ctl_q,
  output logic [31:0] sts_q,
  output logic [63:0] tb_q,
  output logic        fit_irq,
  output logic        wdog_irq,
  output logic        wdog_rst_req
);

  logic [63:0] tb;
  logic [31:0] ctl;
  logic        arm, wis, fis, req;
  logic [1:0]  wrs;
  logic        arm_n, wis_n, fis_n, req_n;
  logic [1:0]  wrs_n;

  function automatic logic [5:0] tap_of(input logic [1:0] code,
                                        input logic [3:0] ext,
                                        input logic [23:0] tbl);
    if (EXT_MODE) return 6'd63 - {ext, code};
    else          return tbl[int'(code) * 6 +: 6];
  endfunction

  wire [63:0] tb_inc  = tb + 64'd1;
  wire [5:0]  fit_tap = tap_of(ctl[25:24], ctl[16:13], FIT_TAPS);
  wire [5:0]  wdg_tap = tap_of(ctl[31:30], ctl[20:17], WDG_TAPS);
  wire        fit_ev  = tick_en & tb_inc[fit_tap] & ~tb[fit_tap];
  wire        wdg_ev  = tick_en & tb_inc[wdg_tap] & ~tb[wdg_tap];

  always_comb begin
    fis_n = (fis & ~(wr_sts & wdata[26])) | fit_ev;
    arm_n = arm & ~(wr_sts & wdata[31]);
    wis_n = wis & ~(wr_sts & wdata[30]);
    wrs_n = wrs & ~({2{wr_sts}} & wdata[29:28]);
    req_n = 1'b0;
    if (wdg_ev) begin
      if (!arm_n)                 arm_n = 1'b1;
      else if (!wis_n)            wis_n = 1'b1;
      else if (ctl[29:28] != 2'd0) begin
        wrs_n = ctl[29:28];
        req_n = 1'b1;
      end
    end
    if (resume) begin
      arm_n = 1'b0;
      wis_n = 1'b0;
      wrs_n = 2'd0;
      req_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb  <= '0;
      ctl <= '0;
      fis <= 1'b0;
      arm <= 1'b0;
      wis <= 1'b0;
      wrs <= 2'd0;
      req <= 1'b0;
    end else begin
      if (tick_en) tb <= tb_inc;
      if (wr_ctl)  ctl <= wdata;
      fis <= fis_n;
      arm <= arm_n;
      wis <= wis_n;
      wrs <= wrs_n;
      req <= req_n;
    end
  end

  assign tb_q         = tb;
  assign ctl_q        = ctl;
  assign sts_q        = {arm, wis, wrs, 1'b0, fis, 26'd0};
  assign fit_irq      = fis & ctl[23];
  assign wdog_irq     = wis & ctl[27];
  assign wdog_rst_req = req;

  p_tb_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> tb_q == $past(tb_q) + 64'd1);
  p_tb_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(tb_q));
  p_fit_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[26]) |-> $past(tick_en));
  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && wdata[26] && !fit_ev) |=> !sts_q[26]);
  p_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[30]) |-> sts_q[31]);
  p_req_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_req |-> sts_q[29:28] != 2'd0);
  p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_req |=> !wdog_rst_req || $past(wdg_ev));
  p_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> sts_q[31:28] == 4'd0 && !wdog_rst_req);
  p_zero_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q[27] == 1'b0 && sts_q[25:0] == 26'd0);

endmodule

// File: tb/sim_tbtap_timer.sv
module sim_tbtap_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic wr_ctl = 1'b0, wr_sts = 1'b0, resume = 1'b0;
  logic [31:0] wdata = '0;
  logic wr_ctl1 = 1'b0;
  logic [31:0] wdata1 = '0;
  logic [31:0] ctl_q, sts_q, ctl1_q, sts1_q;
  logic [63:0] tb_q, tb1_q;
  logic fit_irq, wdog_irq, rst_req, fit1_irq, wdog1_irq, rst1_req;
  int total = 0, bad = 0, reqcnt = 0;

  always #10 clk = ~clk;

  tbtap_timer u0 (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_ctl(wr_ctl),
    .wr_sts(wr_sts), .wdata(wdata), .resume(resume), .ctl_q(ctl_q), .sts_q(sts_q),
    .tb_q(tb_q), .fit_irq(fit_irq), .wdog_irq(wdog_irq), .wdog_rst_req(rst_req));

  tbtap_timer #(.EXT_MODE(1'b1)) u1 (.clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .wr_ctl(wr_ctl1), .wr_sts(1'b0), .wdata(wdata1), .resume(1'b0), .ctl_q(ctl1_q),
    .sts_q(sts1_q), .tb_q(tb1_q), .fit_irq(fit1_irq), .wdog_irq(wdog1_irq),
    .wdog_rst_req(rst1_req));

  always @(negedge clk) if (rst_req) reqcnt++;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk) rst_n = 1'b1;
    reqcnt = 0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk) tick_en = 1'b1;
    @(negedge clk) tick_en = 1'b0;
  endtask

  task automatic put_ctl(input logic [31:0] v);
    @(negedge clk) begin wr_ctl = 1'b1; wdata = v; end
    @(negedge clk) wr_ctl = 1'b0;
  endtask

  task automatic put_sts(input logic [31:0] v);
    @(negedge clk) begin wr_sts = 1'b1; wdata = v; end
    @(negedge clk) wr_sts = 1'b0;
  endtask

  task automatic t_reset_state();
    put_ctl(32'hFFFF_FFFF);
    tick(20);
    do_reset();
    check("R10 ctl", ctl_q, 0);
    check("R10 sts", sts_q, 0);
    check("R10 tb", tb_q, 0);
    check("R10 irq", {fit_irq, wdog_irq, rst_req}, 0);
  endtask

  task automatic t_timebase();
    do_reset();
    tick(5);
    check("R1 count", tb_q, 5);
    repeat (3) @(negedge clk);
    check("R1 hold", tb_q, 5);
  endtask

  task automatic t_readback();
    do_reset();
    put_ctl(32'hA5A5_5A5A);
    check("R11 readback", ctl_q, 32'hA5A5_5A5A);
  endtask

  task automatic t_edge();
    do_reset();
    tick(7);
    check("R4 before rise", sts_q[26], 0);
    tick(1);
    check("R4 on rise", sts_q[26], 1);
    put_sts(32'h0400_0000);
    check("R5 cleared", sts_q[26], 0);
    tick(8);
    check("R4 fall no event", sts_q[26], 0);
    tick(8);
    check("R4 next rise", sts_q[26], 1);
  endtask

  task automatic t_table();
    do_reset();
    put_ctl(32'h0200_0000);
    tick(127);
    check("R2 code2 early", sts_q[26], 0);
    tick(1);
    check("R2 code2 bit7", sts_q[26], 1);
  endtask

  task automatic t_w1c();
    do_reset();
    tick(16);
    check("R5 both set", sts_q, 32'h8400_0000);
    put_sts(32'h0000_0000);
    check("R5 zero write", sts_q, 32'h8400_0000);
    put_sts(32'h0400_0000);
    check("R5 clear one", sts_q, 32'h8000_0000);
  endtask

  task automatic t_irq();
    do_reset();
    put_ctl(32'h0080_0000);
    tick(8);
    check("R6 fit_irq on", fit_irq, 1);
    put_ctl(32'h0000_0000);
    check("R6 fit_irq gated", fit_irq, 0);
    check("R6 status kept", sts_q[26], 1);
  endtask

  task automatic t_watchdog();
    do_reset();
    put_ctl(32'h2800_0000);
    tick(16);
    check("R7 arm", sts_q[31:28], 4'b1000);
    check("R6 wdog_irq off", wdog_irq, 0);
    tick(32);
    check("R7 status", sts_q[31:28], 4'b1100);
    check("R6 wdog_irq on", wdog_irq, 1);
    tick(31);
    check("R8 no early req", reqcnt, 0);
    tick(1);
    check("R8 req pulse", rst_req, 1);
    check("R8 code copied", sts_q[31:28], 4'b1110);
    @(negedge clk);
    check("R8 req one cycle", rst_req, 0);
    @(negedge clk) resume = 1'b1;
    @(negedge clk) resume = 1'b0;
    check("R9 resume", sts_q[31:28], 4'b0000);
    check("R9 irq drop", wdog_irq, 0);
  endtask

  task automatic t_wrc_zero();
    do_reset();
    put_ctl(32'h0800_0000);
    tick(80);
    check("R8 zero ctl no code", sts_q[31:28], 4'b1100);
    check("R8 zero ctl no req", reqcnt, 0);
  endtask

  task automatic t_extended();
    do_reset();
    @(negedge clk) begin wr_ctl1 = 1'b1; wdata1 = 32'h019F_E000; end
    @(negedge clk) wr_ctl1 = 1'b0;
    tick(3);
    check("R3 ext before", sts1_q, 0);
    tick(1);
    check("R3 ext fit bit2", sts1_q, 32'h0400_0000);
    check("R3 ext fit irq", fit1_irq, 1);
    tick(3);
    check("R3 ext wdog early", sts1_q, 32'h0400_0000);
    tick(1);
    check("R3 ext wdog bit3", sts1_q, 32'h8400_0000);
  endtask

  initial begin
    t_reset_state();
    t_timebase();
    t_readback();
    t_edge();
    t_table();
    t_w1c();
    t_irq();
    t_watchdog();
    t_wrc_zero();
    t_extended();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule